// File: doc/BRIEF.md
# PCM Highway Time Slot Assigner

This block places byte-wide voice samples for four channels onto a serial TDM PCM highway and takes them back off it. The whole block runs on the PCM bit clock. An 8 kHz frame sync, sampled on the rising clock edge, opens bit period 0 of a frame. Each channel has a slot number (0–127) and a clock-slot offset (0–7). Its burst starts at bit period `slot*8 + offset`, counted from that frame start. A burst is 8 bits in compressed mode. It is 16 bits when the channel's linear mode or signaling is on.

Transmit bits come from a per-channel parallel word. They are shifted out most significant bit first on highway port A, port B or both. Each port drives its data line only inside an enabled burst and is high impedance at all other times. While a port drives, its active-low slot strobe is held low. When the strobe is released it reads 1. A single edge-select input chooses whether transmit bits are launched on the rising or the falling clock edge.

Receive bits for each channel are taken from one selected port. They are sampled on the clock edge opposite to the launch edge and assembled into a parallel word. That word appears together with a one-cycle valid pulse.

Top module: `tsa_top`

## Requirements
- R1: The rising clock edge that samples `fs` high opens bit period 0. Each later edge advances the period by one. A channel's burst occupies periods `ch_slot*8 + ch_cslot` up to that value plus the burst length minus one.
- R2: Serial data on both directions is most significant bit first. In transmit, the first burst period carries word bit L-1.
- R3: The burst length L is 8 when both `ch_linear` and `ch_sig` of the channel are 0, and 16 otherwise. In 8-bit mode, transmit bits come from `tx_words` bits [7:0] of the channel.
- R4: A channel drives nothing when it is inactive with signaling off (`ch_active`=0 and `ch_sig`=0). It also drives nothing when `ch_cutoff`=1. Outside all enabled bursts, a port's data line is high impedance.
- R5: `tsc_a_n` / `tsc_b_n` is 0 exactly while its port drives a bit, and 1 otherwise.
- R6: With `launch_rise`=1, the bit of period k is driven from the rising edge that opens period k. With `launch_rise`=0, it is driven from the falling edge in the middle of period k.
- R7: `ch_tx_a` / `ch_tx_b` route a channel's transmit burst to port A, port B or both. `ch_rx_b`=1 takes receive data from `dr_b`, and 0 takes it from `dr_a`.
- R8: For an active channel, the receive bit of period k is sampled on the falling edge inside period k when `launch_rise`=1, and on the rising edge that ends period k when `launch_rise`=0. After the last burst bit, `rx_valid` pulses for one cycle during the next period. At the same time `rx_words` holds the burst, MSB first, zero-extended to 16 bits in 8-bit mode. Inactive channels give no valid pulse.
- R9: A frame sync that arrives early resets the period count to 0. Any burst in progress is cut off: its port returns to high impedance or to what period 0 calls for, and an interrupted receive burst gives no valid pulse.
- R10: When enabled bursts of two channels overlap on one port, the lower-numbered channel drives.
- R11: During reset both strobes read 1, both data lines are high impedance, and no valid pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync, sampled on the rising edge |
| launch_rise | input | 1 | 1: launch transmit on the rising edge, 0: on the falling edge |
| ch_active | input | 4 | Per-channel active flag |
| ch_sig | input | 4 | Per-channel signaling enable (forces 16-bit bursts and transmit) |
| ch_linear | input | 4 | Per-channel linear (16-bit) mode |
| ch_cutoff | input | 4 | Per-channel transmit cutoff |
| ch_tx_a | input | 4 | Per-channel route to port A |
| ch_tx_b | input | 4 | Per-channel route to port B |
| ch_rx_b | input | 4 | Per-channel receive port select (1 = B) |
| ch_slot | input | 28 | Slot number, 7 bits per channel, channel 0 in the low bits |
| ch_cslot | input | 12 | Clock-slot offset, 3 bits per channel |
| tx_words | input | 64 | Transmit words, 16 bits per channel |
| dr_a | input | 1 | Receive serial data, port A |
| dr_b | input | 1 | Receive serial data, port B |
| dx_a | output | 1 | Transmit serial data, port A, tri-state |
| dx_b | output | 1 | Transmit serial data, port B, tri-state |
| tsc_a_n | output | 1 | Active-low slot strobe, port A |
| tsc_b_n | output | 1 | Active-low slot strobe, port B |
| rx_words | output | 64 | Received words, 16 bits per channel |
| rx_valid | output | 4 | One-cycle valid pulse per channel |

## Verification
A wrong period count shows up within the first burst after a frame sync. The strobes then open at the wrong period, or a valid pulse lands a period early or late. A bad bit index or a wrong burst length corrupts the serial bit stream within the same burst. A receive shifter sampling on the wrong edge picks up the deliberately corrupted half-period of `dr_a`/`dr_b`, so it shows up in the very next received word. A missed resynchronisation leaves the strobe low, or produces a stray valid pulse, within one period of the early frame sync.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NUM_CH      = 4;
  localparam int SLOT_W      = 7;
  localparam int CSLOT_W     = 3;
  localparam int BYTE_BITS   = 8;
  localparam int WORD_BITS   = 2 * BYTE_BITS;
  localparam int FRAME_SLOTS = 1 << SLOT_W;
  localparam int FRAME_BITS  = FRAME_SLOTS * BYTE_BITS;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int POS_W       = CNT_W + 1;
  localparam int IDX_W       = $clog2(WORD_BITS);

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    logic             hit;
    logic             last;
    logic [IDX_W-1:0] idx;
  } burst_t;

  // First bit period of a burst.
  function automatic pos_t burst_start(input logic [SLOT_W-1:0] slot,
                                       input logic [CSLOT_W-1:0] cs);
    return pos_t'(slot) * pos_t'(BYTE_BITS) + pos_t'(cs);
  endfunction

  function automatic pos_t burst_len(input logic wide);
    return wide ? pos_t'(WORD_BITS) : pos_t'(BYTE_BITS);
  endfunction

  // Where a period falls relative to a burst; idx is the word bit (MSB first).
  function automatic burst_t locate(input cnt_t cnt, input pos_t start, input pos_t len);
    burst_t r;
    pos_t   off;
    off    = pos_t'(cnt) - start;
    r.hit  = (pos_t'(cnt) >= start) && (off < len);
    r.last = r.hit && (off == len - pos_t'(1));
    r.idx  = IDX_W'(len - pos_t'(1) - off);
    return r;
  endfunction

  function automatic logic [1:0] tx_sample(input cnt_t cnt, input pos_t start, input pos_t len,
                                           input logic [WORD_BITS-1:0] word);
    burst_t b;
    b = locate(cnt, start, len);
    return {b.hit, word[b.idx]};
  endfunction

  // {drive, bit} of the lowest-numbered requesting channel.
  function automatic logic [1:0] pick(input logic [NUM_CH-1:0] en, input logic [NUM_CH-1:0] bits);
    logic [1:0] r;
    r = 2'b00;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en[i]) r = {1'b1, bits[i]};
    end
    return r;
  endfunction
endpackage

// File: rtl/tsa_frame_counter.sv
module tsa_frame_counter
  import tsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  output cnt_t cnt,
  output cnt_t cnt_nxt
);
  always_comb begin
    if (fs)                                cnt_nxt = '0;
    else if (cnt == cnt_t'(FRAME_BITS-1))  cnt_nxt = '0;
    else                                   cnt_nxt = cnt + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tsa_chan_slot.sv
module tsa_chan_slot
  import tsa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  cnt_t                 cnt,
  input  cnt_t                 cnt_nxt,
  input  logic                 active,
  input  logic                 sig,
  input  logic                 linear,
  input  logic                 cutoff,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [CSLOT_W-1:0]   cslot,
  input  logic [WORD_BITS-1:0] tx_word,
  input  logic                 rx_bit,
  output logic                 tx_now,
  output logic                 tx_now_bit,
  output logic                 tx_nxt,
  output logic                 tx_nxt_bit,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_valid
);
  pos_t   start;
  pos_t   len;
  logic   wide;
  logic   may_tx;
  burst_t here;
  logic [1:0] ahead;
  logic [WORD_BITS-2:0] shreg;

  assign wide   = linear | sig;
  assign start  = burst_start(slot, cslot);
  assign len    = burst_len(wide);
  assign here   = locate(cnt, start, len);
  assign ahead  = tx_sample(cnt_nxt, start, len, tx_word);
  assign may_tx = (active | sig) & ~cutoff;

  assign tx_now     = may_tx & here.hit;
  assign tx_now_bit = tx_word[here.idx];
  assign tx_nxt     = may_tx & ahead[1];
  assign tx_nxt_bit = ahead[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= active & here.last;
      if (active && here.hit) shreg <= {shreg[WORD_BITS-3:0], rx_bit};
      if (active && here.last) begin
        if (wide) rx_word <= {shreg, rx_bit};
        else      rx_word <= {{BYTE_BITS{1'b0}}, shreg[BYTE_BITS-2:0], rx_bit};
      end
    end
  end
endmodule

// File: rtl/tsa_port_drive.sv
module tsa_port_drive
  import tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_rise,
  input  logic [NUM_CH-1:0] now_en,
  input  logic [NUM_CH-1:0] now_bit,
  input  logic [NUM_CH-1:0] nxt_en,
  input  logic [NUM_CH-1:0] nxt_bit,
  output logic [1:0]        drv
);
  logic [1:0] rise_q;
  logic [1:0] fall_q;

  // Rising launch: register the value of the period being opened.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 2'b00;
    else        rise_q <= pick(nxt_en, nxt_bit);
  end

  // Falling launch: register the current period half a cycle in.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 2'b00;
    else        fall_q <= pick(now_en, now_bit);
  end

  assign drv = launch_rise ? rise_q : fall_q;
endmodule

// File: rtl/tsa_top.sv
module tsa_top
  import tsa_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fs,
  input  logic                        launch_rise,
  input  logic [NUM_CH-1:0]           ch_active,
  input  logic [NUM_CH-1:0]           ch_sig,
  input  logic [NUM_CH-1:0]           ch_linear,
  input  logic [NUM_CH-1:0]           ch_cutoff,
  input  logic [NUM_CH-1:0]           ch_tx_a,
  input  logic [NUM_CH-1:0]           ch_tx_b,
  input  logic [NUM_CH-1:0]           ch_rx_b,
  input  logic [NUM_CH*SLOT_W-1:0]    ch_slot,
  input  logic [NUM_CH*CSLOT_W-1:0]   ch_cslot,
  input  logic [NUM_CH*WORD_BITS-1:0] tx_words,
  input  logic                        dr_a,
  input  logic                        dr_b,
  output logic                        dx_a,
  output logic                        dx_b,
  output logic                        tsc_a_n,
  output logic                        tsc_b_n,
  output logic [NUM_CH*WORD_BITS-1:0] rx_words,
  output logic [NUM_CH-1:0]           rx_valid
);
  cnt_t frame_pos;
  cnt_t frame_pos_nxt;
  logic [NUM_CH-1:0] now_en, now_bit, nxt_en, nxt_bit, rx_bit_sel;
  logic dr_a_fall, dr_b_fall;
  logic [1:0] drv_a, drv_b;

  tsa_frame_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .fs(fs), .cnt(frame_pos), .cnt_nxt(frame_pos_nxt)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_a_fall <= 1'b0;
      dr_b_fall <= 1'b0;
    end else begin
      dr_a_fall <= dr_a;
      dr_b_fall <= dr_b;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rx_bit_sel[c] = ch_rx_b[c] ? (launch_rise ? dr_b_fall : dr_b)
                                      : (launch_rise ? dr_a_fall : dr_a);
    tsa_chan_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (frame_pos),
      .cnt_nxt   (frame_pos_nxt),
      .active    (ch_active[c]),
      .sig       (ch_sig[c]),
      .linear    (ch_linear[c]),
      .cutoff    (ch_cutoff[c]),
      .slot      (ch_slot[c*SLOT_W +: SLOT_W]),
      .cslot     (ch_cslot[c*CSLOT_W +: CSLOT_W]),
      .tx_word   (tx_words[c*WORD_BITS +: WORD_BITS]),
      .rx_bit    (rx_bit_sel[c]),
      .tx_now    (now_en[c]),
      .tx_now_bit(now_bit[c]),
      .tx_nxt    (nxt_en[c]),
      .tx_nxt_bit(nxt_bit[c]),
      .rx_word   (rx_words[c*WORD_BITS +: WORD_BITS]),
      .rx_valid  (rx_valid[c])
    );
  end

  tsa_port_drive u_port_a (
    .clk(clk), .rst_n(rst_n), .launch_rise(launch_rise),
    .now_en(now_en & ch_tx_a), .now_bit(now_bit),
    .nxt_en(nxt_en & ch_tx_a), .nxt_bit(nxt_bit), .drv(drv_a)
  );

  tsa_port_drive u_port_b (
    .clk(clk), .rst_n(rst_n), .launch_rise(launch_rise),
    .now_en(now_en & ch_tx_b), .now_bit(now_bit),
    .nxt_en(nxt_en & ch_tx_b), .nxt_bit(nxt_bit), .drv(drv_b)
  );

  assign dx_a    = drv_a[1] ? drv_a[0] : 1'bz;
  assign dx_b    = drv_b[1] ? drv_b[0] : 1'bz;
  assign tsc_a_n = ~drv_a[1];
  assign tsc_b_n = ~drv_b[1];
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker
  import tsa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fs,
  input cnt_t              cnt,
  input logic [NUM_CH-1:0] ch_active,
  input logic [NUM_CH-1:0] ch_sig,
  input logic [NUM_CH-1:0] ch_cutoff,
  input logic              tsc_a_n,
  input logic              tsc_b_n,
  input logic [NUM_CH-1:0] rx_valid
);
  logic [NUM_CH-1:0] tx_allow;
  assign tx_allow = (ch_active | ch_sig) & ~ch_cutoff;

  p_sync_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> (cnt == '0));

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |=> (cnt == cnt_t'($past(cnt) + 1'b1)));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> ((rx_valid & $past(rx_valid)) == '0));

  p_valid_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> ((rx_valid & ~$past(ch_active)) == '0));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_allow == '0 && $past(tx_allow) == '0) |-> (tsc_a_n && tsc_b_n));
endmodule

bind tsa_top tsa_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fs       (fs),
  .cnt      (frame_pos),
  .ch_active(ch_active),
  .ch_sig   (ch_sig),
  .ch_cutoff(ch_cutoff),
  .tsc_a_n  (tsc_a_n),
  .tsc_b_n  (tsc_b_n),
  .rx_valid (rx_valid)
);

// File: tb/tb_tsa_top.sv
module tb_tsa_top;
  import tsa_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fs, edge_r, dr_a, dr_b;
  logic       c_act [NUM_CH];
  logic       c_sig [NUM_CH];
  logic       c_lin [NUM_CH];
  logic       c_cut [NUM_CH];
  logic       c_txa [NUM_CH];
  logic       c_txb [NUM_CH];
  logic       c_rxb [NUM_CH];
  logic [6:0] c_slot[NUM_CH];
  logic [2:0] c_cs  [NUM_CH];
  logic [15:0] c_word[NUM_CH];

  logic [NUM_CH-1:0] act_v, sig_v, lin_v, cut_v, txa_v, txb_v, rxb_v;
  logic [NUM_CH*SLOT_W-1:0]    slot_v;
  logic [NUM_CH*CSLOT_W-1:0]   cs_v;
  logic [NUM_CH*WORD_BITS-1:0] word_v;
  wire dx_a, dx_b, tsc_a_n, tsc_b_n;
  logic [NUM_CH*WORD_BITS-1:0] rx_words;
  logic [NUM_CH-1:0] rx_valid;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pack
    assign act_v[g] = c_act[g];
    assign sig_v[g] = c_sig[g];
    assign lin_v[g] = c_lin[g];
    assign cut_v[g] = c_cut[g];
    assign txa_v[g] = c_txa[g];
    assign txb_v[g] = c_txb[g];
    assign rxb_v[g] = c_rxb[g];
    assign slot_v[g*SLOT_W +: SLOT_W]    = c_slot[g];
    assign cs_v[g*CSLOT_W +: CSLOT_W]    = c_cs[g];
    assign word_v[g*WORD_BITS +: WORD_BITS] = c_word[g];
  end

  tsa_top dut (
    .clk(clk), .rst_n(rst_n), .fs(fs), .launch_rise(edge_r),
    .ch_active(act_v), .ch_sig(sig_v), .ch_linear(lin_v), .ch_cutoff(cut_v),
    .ch_tx_a(txa_v), .ch_tx_b(txb_v), .ch_rx_b(rxb_v),
    .ch_slot(slot_v), .ch_cslot(cs_v), .tx_words(word_v),
    .dr_a(dr_a), .dr_b(dr_b), .dx_a(dx_a), .dx_b(dx_b),
    .tsc_a_n(tsc_a_n), .tsc_b_n(tsc_b_n), .rx_words(rx_words), .rx_valid(rx_valid)
  );

  int tests = 0;
  int fails = 0;
  int bk = 0;
  int tick = 0;
  bit started = 0;
  bit sync_pending = 0;
  bit done = 0;
  string tx_tag = "R1";
  string rx_tag = "R8";
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] acc [NUM_CH];

  typedef struct {
    int          ch;
    int          due;
    logic [15:0] word;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (period %0d)", req, act, exp, bk);
    end
  endtask

  // Expected {drive, bit} for a port in bit period k; lowest channel wins.
  function automatic logic [1:0] exp_tx(input int port, input int k);
    for (int c = 0; c < NUM_CH; c++) begin
      int first = c_slot[c] * 8 + c_cs[c];
      int n = (c_lin[c] || c_sig[c]) ? 16 : 8;
      bit on_port = (port == 0) ? c_txa[c] : c_txb[c];
      bit allowed = (c_act[c] || c_sig[c]) && !c_cut[c];
      if (allowed && on_port && k >= first && k < first + n)
        return {1'b1, c_word[c][n - 1 - (k - first)]};
    end
    return 2'b00;
  endfunction

  task automatic rx_model(input logic va, input logic vb);
    for (int c = 0; c < NUM_CH; c++) begin
      int first = c_slot[c] * 8 + c_cs[c];
      int n = (c_lin[c] || c_sig[c]) ? 16 : 8;
      logic b;
      b = c_rxb[c] ? vb : va;
      if (c_act[c] && bk >= first && bk < first + n) begin
        acc[c] = (bk == first) ? {15'b0, b} : {acc[c][14:0], b};
        if (bk == first + n - 1)
          sb.push_back('{ch: c, due: tick, word: (n == 16) ? acc[c] : {8'h00, acc[c][7:0]}, tag: rx_tag});
      end
    end
  endtask

  task automatic tx_checks();
    logic [1:0] ea, eb;
    ea = exp_tx(0, bk);
    eb = exp_tx(1, bk);
    check(ea[1] ? "R5" : "R4", {15'b0, tsc_a_n}, {15'b0, ~ea[1]});
    check(eb[1] ? "R5" : "R4", {15'b0, tsc_b_n}, {15'b0, ~eb[1]});
    if (ea[1]) check(tx_tag, {15'b0, dx_a}, {15'b0, ea[0]});
    if (eb[1]) check(tx_tag, {15'b0, dx_b}, {15'b0, eb[0]});
  endtask

  // One bit period: drive receive data on the launch edge, corrupt it in the half the DUT must not sample.
  task automatic step(input bit fs_next);
    logic va, vb;
    @(posedge clk);
    if (sync_pending) begin bk = 0; started = 1; end
    else bk = bk + 1;
    tick++;
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    va = lfsr[3];
    vb = lfsr[9];
    if (started) rx_model(va, vb);
    dr_a = edge_r ? va : ~va;
    dr_b = edge_r ? vb : ~vb;
    #10;
    if (!edge_r) begin dr_a = va; dr_b = vb; end
    #3;
    if (started) tx_checks();
    if (edge_r) begin dr_a = ~va; dr_b = ~vb; end
    fs = fs_next;
    sync_pending = fs_next;
  endtask

  task automatic frame(input int len);
    for (int k = 0; k < len; k++) step(k == len - 1);
  endtask

  task automatic set_ch(input int c, input logic a, input logic s, input logic l, input logic x,
                        input logic ta, input logic tb, input logic rb, input int sl, input int cs,
                        input logic [15:0] w);
    c_act[c] = a; c_sig[c] = s; c_lin[c] = l; c_cut[c] = x;
    c_txa[c] = ta; c_txb[c] = tb; c_rxb[c] = rb;
    c_slot[c] = 7'(sl); c_cs[c] = 3'(cs); c_word[c] = w;
  endtask

  task automatic cfg_base();
    set_ch(0, 1, 0, 0, 0, 1, 0, 0, 1, 0, 16'h3CA5);  // 8-bit, periods 8..15, port A
    set_ch(1, 1, 0, 1, 0, 0, 1, 1, 3, 3, 16'h9E37);  // linear, periods 27..42, port B
    set_ch(2, 1, 1, 0, 0, 1, 1, 1, 6, 5, 16'hC3A1);  // signaling, periods 53..68, both ports
    set_ch(3, 0, 0, 0, 0, 1, 0, 0, 9, 0, 16'hFFFF);  // inactive, no signaling: silent
  endtask

  task automatic bump_words();
    for (int c = 0; c < NUM_CH; c++) c_word[c] = {c_word[c][10:0], c_word[c][15:11]} ^ 16'h5A3C;
  endtask

  always @(posedge clk) begin : monitor
    exp_t e;
    logic [NUM_CH-1:0] seen;
    #14;
    if (started && !done) begin
      seen = '0;
      while (sb.size() > 0 && sb[0].due == tick - 1) begin
        e = sb.pop_front();
        seen[e.ch] = 1'b1;
        check(e.tag, {15'b0, rx_valid[e.ch]}, 16'h0001);
        check(e.tag, rx_words[e.ch*WORD_BITS +: WORD_BITS], e.word);
      end
      check(rx_tag, {12'b0, rx_valid & ~seen}, 16'h0000);
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fs = 1'b0; dr_a = 1'b0; dr_b = 1'b0; edge_r = 1'b1;
    for (int c = 0; c < NUM_CH; c++) acc[c] = '0;
    cfg_base();
    repeat (3) @(posedge clk);
    #15;
    check("R11", {14'b0, tsc_a_n, tsc_b_n}, 16'h0003);
    check("R11", {12'b0, rx_valid}, 16'h0000);
    @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b1);

    // Basic placement, MSB order, lengths, routing.
    tx_tag = "R1 R2 R3 R7";
    for (int f = 0; f < 3; f++) begin frame(96); bump_words(); end

    // Falling-edge launch, opposite-edge receive.
    edge_r = 1'b0;
    tx_tag = "R6";
    for (int f = 0; f < 2; f++) begin frame(96); bump_words(); end

    // Cutoff and overlap priority on port A.
    edge_r = 1'b1;
    tx_tag = "R4 R10";
    c_cut[0] = 1'b1;
    c_txa[1] = 1'b1; c_rxb[1] = 1'b0;
    c_slot[2] = 7'd3; c_cs[2] = 3'd7;               // periods 31..46, overlaps channel 1
    for (int f = 0; f < 2; f++) begin frame(96); bump_words(); end

    // Early frame sync in the middle of channel 1's burst.
    cfg_base();
    tx_tag = "R9";
    rx_tag = "R9";
    frame(96);
    frame(31);
    frame(96);
    frame(96);
    step(1'b0);
    step(1'b0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule